// File: doc/BRIEF.md
# Self-correcting modulo-6 counter

This block is a three-bit synchronous counter whose bits are called A (most significant), B and C. It steps through six valid codes in a fixed cycle that is not plain binary: 000, 001, 010, 100, 101, 110, then back to 000. Each bit is modelled as a JK flip-flop with fixed input equations. A toggles whenever B is 1. B has J = C and K = 1. C has J = not B and K = 1. All three bits follow Q+ = J·Q' + K'·Q, and they update only on a clock edge where the count enable is high.

The codes 011 and 111 are unused. The same equations lead the counter out of them in a single enabled clock: 011 goes to 100 and 111 goes to 000. From there the normal cycle resumes. A valid flag is low while the state holds an unused code. A synchronous reset forces 000, and it takes priority over the enable.

The named states are the six valid states S000, S001, S010, S100, S101 and S110, and the two unused states U011 and U111. The named transitions are the six steps of the cycle (S000→S001, S001→S010, S010→S100, S100→S101, S101→S110, S110→S000) and the two recovery steps (U011→S100, U111→S000). The same transitions apply to every state on every enabled edge.

Top module: `sc_mod6_counter`

## Requirements
- R1: A clock edge with the reset high sets the state to 000 and the valid flag to 1, whatever the enable is.
- R2: A clock edge with the reset low and the enable low leaves the state unchanged.
- R3: With the enable high on every edge, the state visits 000, 001, 010, 100, 101, 110 in that order and returns to 000 after 110.
- R4: From the unused code 011, one enabled clock edge gives 100.
- R5: From the unused code 111, one enabled clock edge gives 000.
- R6: The valid flag is 0 when the state is 011 or 111 and 1 for every other code.
- R7: On each enabled edge, bit A (state bit 2) inverts exactly when bit B (state bit 1) was 1.
- R8: On each enabled edge, the next B (bit 1) is C and not B, and the next C (bit 0) is not B and not C, both using the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the state updates on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high; forces 000 |
| en_i | input | 1 | Count enable; the state updates only when this is high |
| state_o | output | 3 | Counter state: bit 2 is A, bit 1 is B, bit 0 is C |
| valid_o | output | 1 | High when the state is one of the six valid codes |

## Verification
The state is due one rising edge after the inputs that produce it. The valid flag is decoded from the state with no register of its own, so it is due in the same cycle as the state. The bench drives inputs at the falling edge and samples one time unit after the rising edge, so each check sees exactly one edge's worth of change. The unused codes cannot be reached through the ports. To test them, the bench forces the three flip-flop bits during a low clock phase and checks the valid flag before the next edge. It then checks the recovered state one edge later.

// File: rtl/sc_mod6_pkg.sv
package sc_mod6_pkg;

    localparam int unsigned CNT_BITS = 3;
    localparam int unsigned BIT_A    = 2;
    localparam int unsigned BIT_B    = 1;
    localparam int unsigned BIT_C    = 0;

    typedef logic [CNT_BITS-1:0] cnt_t;

    typedef enum logic [CNT_BITS-1:0] {
        S000 = 3'b000,
        S001 = 3'b001,
        S010 = 3'b010,
        U011 = 3'b011,
        S100 = 3'b100,
        S101 = 3'b101,
        S110 = 3'b110,
        U111 = 3'b111
    } cnt_state_e;

    localparam cnt_t RESET_CODE = cnt_t'(S000);

endpackage

// File: rtl/sc_jk_flop.sv
module sc_jk_flop #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic j_i,
    input  logic k_i,
    output logic q_o
);

    logic q_r;

    // JK rule: set on J, keep unless K, so J=K=1 toggles
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q_r <= RST_VAL;
        end else if (en_i) begin
            q_r <= (j_i & ~q_r) | (~k_i & q_r);
        end
    end

    assign q_o = q_r;

endmodule

// File: rtl/sc_mod6_jk_drive.sv
module sc_mod6_jk_drive
    import sc_mod6_pkg::*;
(
    input  cnt_t state_i,
    output cnt_t j_o,
    output cnt_t k_o
);

    logic b_now;
    logic c_now;

    assign b_now = state_i[BIT_B];
    assign c_now = state_i[BIT_C];

    always_comb begin
        // A: toggle when B is set
        j_o[BIT_A] = b_now;
        k_o[BIT_A] = b_now;
        // B: set from C, always clear when held
        j_o[BIT_B] = c_now;
        k_o[BIT_B] = 1'b1;
        // C: set from complement of B, always clear when held
        j_o[BIT_C] = ~b_now;
        k_o[BIT_C] = 1'b1;
    end

endmodule

// File: rtl/sc_mod6_decode.sv
module sc_mod6_decode
    import sc_mod6_pkg::*;
(
    input  cnt_t state_i,
    output logic valid_o
);

    cnt_state_e st;

    assign st = cnt_state_e'(state_i);

    always_comb begin
        unique case (st)
            S000, S001, S010,
            S100, S101, S110: valid_o = 1'b1;
            U011, U111:       valid_o = 1'b0;
            default:          valid_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sc_mod6_counter.sv
module sc_mod6_counter
    import sc_mod6_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                en_i,
    output logic [CNT_BITS-1:0] state_o,
    output logic                valid_o
);

    cnt_t state_q;
    cnt_t jk_j;
    cnt_t jk_k;

    sc_mod6_jk_drive u_drive (
        .state_i (state_q),
        .j_o     (jk_j),
        .k_o     (jk_k)
    );

    for (genvar gi = 0; gi < CNT_BITS; gi++) begin : g_bit
        sc_jk_flop #(
            .RST_VAL (RESET_CODE[gi])
        ) u_jk (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .en_i  (en_i),
            .j_i   (jk_j[gi]),
            .k_i   (jk_k[gi]),
            .q_o   (state_q[gi])
        );
    end

    sc_mod6_decode u_dec (
        .state_i (state_q),
        .valid_o (valid_o)
    );

    assign state_o = state_q;

endmodule

// File: rtl/sc_mod6_counter_chk.sv
module sc_mod6_counter_chk
    import sc_mod6_pkg::*;
(
    input logic                clk_i,
    input logic                rst_i,
    input logic                en_i,
    input logic [CNT_BITS-1:0] state_o,
    input logic                valid_o
);

    // R2: a disabled edge holds the state
    p_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rst_i && !en_i) |=> $stable(state_o))
        else $error("p_hold_r2");

    // R3: a valid state never leads to an unused one
    p_cycle_closed_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rst_i && en_i && valid_o) |=> valid_o)
        else $error("p_cycle_closed_r3");

    // R4: recovery from 011
    p_recover_011_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rst_i && en_i && state_o == 3'b011) |=> (state_o == 3'b100))
        else $error("p_recover_011_r4");

    // R5: recovery from 111
    p_recover_111_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rst_i && en_i && state_o == 3'b111) |=> (state_o == 3'b000))
        else $error("p_recover_111_r5");

    // R6: a low flag implies B and C are both set
    p_flag_code_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_o |-> (state_o[BIT_B] && state_o[BIT_C]))
        else $error("p_flag_code_r6");

    // R7: A inverts exactly when the old B was set
    p_a_toggle_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rst_i && en_i) |=>
            (state_o[BIT_A] == ($past(state_o[BIT_A]) ^ $past(state_o[BIT_B]))))
        else $error("p_a_toggle_r7");

    // R8: B and C next-state equations
    p_bc_next_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rst_i && en_i) |=>
            (state_o[BIT_B] == ($past(state_o[BIT_C]) & ~$past(state_o[BIT_B])) &&
             state_o[BIT_C] == (~$past(state_o[BIT_B]) & ~$past(state_o[BIT_C]))))
        else $error("p_bc_next_r8");

endmodule

bind sc_mod6_counter sc_mod6_counter_chk u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (en_i),
    .state_o (state_o),
    .valid_o (valid_o)
);

// File: tb/tb_sc_mod6_counter.sv
`timescale 1ns/1ps
module tb_sc_mod6_counter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [2:0] state;
    logic       valid;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    sc_mod6_counter dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .en_i    (en),
        .state_o (state),
        .valid_o (valid)
    );

    // Row layout: {rst, en, expected state[2:0], expected valid}
    localparam int NVEC = 12;
    localparam logic [5:0] VEC [NVEC] = '{
        6'b11_000_1,  // R1: reset with enable high
        6'b01_001_1,  // R3
        6'b01_010_1,  // R3
        6'b00_010_1,  // R2: hold
        6'b01_100_1,  // R3, R7
        6'b01_101_1,  // R3
        6'b00_101_1,  // R2: hold
        6'b01_110_1,  // R3, R8
        6'b01_000_1,  // R3: wrap, R7
        6'b01_001_1,  // R3
        6'b10_000_1,  // R1: reset with enable low
        6'b01_001_1   // R3
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic e);
        @(negedge clk);
        rst = r;
        en  = e;
        @(posedge clk);
        #1;
    endtask

    // Place an unused code in the flops during a low clock phase
    task automatic inject(input logic [2:0] code);
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b0;
        @(posedge clk);
        @(negedge clk);
        if (code[2]) force dut.g_bit[2].u_jk.q_r = 1'b1; else force dut.g_bit[2].u_jk.q_r = 1'b0;
        if (code[1]) force dut.g_bit[1].u_jk.q_r = 1'b1; else force dut.g_bit[1].u_jk.q_r = 1'b0;
        if (code[0]) force dut.g_bit[0].u_jk.q_r = 1'b1; else force dut.g_bit[0].u_jk.q_r = 1'b0;
        rst = 1'b0;
        #1;
        release dut.g_bit[2].u_jk.q_r;
        release dut.g_bit[1].u_jk.q_r;
        release dut.g_bit[0].u_jk.q_r;
        #1;
    endtask

    initial begin
        #(8 * 5000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(1'b1, 1'b0);
        check("R1 reset", {state, valid}, 4'b000_1);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][5], VEC[i][4]);
            check(VEC[i][5] ? "R1 vector" : (VEC[i][4] ? "R3 vector" : "R2 vector"),
                  {state, valid}, VEC[i][3:0]);
        end

        // R2: long hold from a valid state
        step(1'b0, 1'b1);  // 001 -> 010
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b0);
            check("R2 long hold", {state, valid}, 4'b010_1);
        end

        // R4 / R6: recovery from 011
        inject(3'b011);
        check("R6 flag low at 011", {state, valid}, 4'b011_0);
        step(1'b0, 1'b0);
        check("R2 hold at 011", {state, valid}, 4'b011_0);
        step(1'b0, 1'b1);
        check("R4 011 -> 100", {state, valid}, 4'b100_1);
        step(1'b0, 1'b1);
        check("R3 resume after 011", {state, valid}, 4'b101_1);

        // R5 / R6: recovery from 111
        inject(3'b111);
        check("R6 flag low at 111", {state, valid}, 4'b111_0);
        step(1'b0, 1'b1);
        check("R5 111 -> 000", {state, valid}, 4'b000_1);
        step(1'b0, 1'b1);
        check("R3 resume after 111", {state, valid}, 4'b001_1);

        // R1: reset out of an unused code
        inject(3'b111);
        step(1'b1, 1'b1);
        check("R1 reset from 111", {state, valid}, 4'b000_1);

        // R7 / R8: a full lap, each step checked
        begin
            logic [2:0] ref_s;
            ref_s = 3'b000;
            for (int i = 0; i < 7; i++) begin
                logic [2:0] nxt;
                nxt[2] = ref_s[2] ^ ref_s[1];
                nxt[1] = ref_s[0] & ~ref_s[1];
                nxt[0] = ~ref_s[1] & ~ref_s[0];
                step(1'b0, 1'b1);
                check("R7 R8 lap", {state, valid}, {nxt, 1'b1});
                ref_s = nxt;
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule